// File: doc/BRIEF.md
# Switched Full-Duplex Nibble Transmit Sequencer

This block sends Ethernet frames four bits at a time on a media-independent style transmit pair (`txd`, `txen`), for a point-to-point link in full duplex. It is always in switched full-duplex mode. It never waits on carrier sense. The collision input is not a real collision here: the far end uses it to ask this end to pause. A frame starts when `tx_req` is seen high while the sequencer is idle. The sequencer then sends a preamble of fifteen `5h` nibbles and a `Dh` start nibble. After that it pulls one data nibble per clock from a source using `src_rd`, `src_nib` and `src_last`. Once the last nibble has gone out, it holds the line idle for a 24-clock gap.

When the pause input is seen, the sequencer sends one jam nibble and then one idle backoff clock. It then waits out the full gap and sends the whole frame again from its first preamble nibble. The `src_rewind` pulse tells the source to return to its first nibble. A pause seen during the preamble is held until the whole preamble has gone out. No attempt count or retry limit is kept. A loopback control silences the line outputs and blocks the pause input, while the internal sequencing keeps running.

Top module: `sfd_tx_seq`

## Requirements
- R1: While `rst_n` is low, `txen`, `txd`, `tx_done` and `src_rewind` are all 0.
- R2: One clock after the idle sequencer samples `tx_req` high, `txen` goes high. `txd` then carries `5h` for 15 clocks, followed by `Dh` for 1 clock.
- R3: After the `Dh` nibble, each clock drives `txd = src_nib` with `txen = 1` and `src_rd = 1`. `tx_done` is high in the clock of the nibble where `src_last` is high and `col` is low. The next 24 clocks have `txen = 0` and `txd = 0h`, and only after them is `tx_req` sampled again.
- R4: `crs` has no effect. A frame starts and runs with the same timing whether `crs` is 0 or 1.
- R5: `col` high in a data clock lets that nibble go out. The next clock is a single jam clock with `txd = 5h`, `txen = 1` and `src_rewind = 1`. The clock after it is a backoff clock with `txen = 0`, `txd = 0h`, followed by the 24 idle gap clocks. `tx_done` stays low for that attempt.
- R6: `col` high in any preamble clock, the `Dh` clock included, does not cut the preamble short. The jam clock comes directly after the `Dh` nibble.
- R7: After the gap that follows a jam, the frame restarts at its first preamble nibble without a new `tx_req`. This repeats for every pause event with no limit.
- R8: While `loopback` is 1, `txd = 0h` and `txen = 0`, and `col` is ignored. The frame still completes with `tx_done` at the clean-frame time and no `src_rewind`.
- R9: `col` high in idle, gap, jam or backoff clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loopback | input | 1 | Silence line outputs and block line inputs |
| tx_req | input | 1 | Frame start request, sampled while idle |
| tx_done | output | 1 | Final data nibble of a successful attempt |
| src_nib | input | 4 | Current data nibble from the source |
| src_last | input | 1 | Current source nibble is the final one |
| src_rd | output | 1 | Source nibble consumed this clock |
| src_rewind | output | 1 | Source must return to its first nibble |
| crs | input | 1 | Carrier sense (ignored) |
| col | input | 1 | Pause request from the link partner |
| txd | output | 4 | Transmit nibble |
| txen | output | 1 | Transmit enable |

## Verification
Two things can happen in the same clock. A pause can arrive on the final data nibble, which is also the clock in which the frame would finish. A pause can also arrive on the `Dh` nibble, which is the clock in which the preamble hands over to data. The bench covers both by raising `col` exactly in those clocks, for several frame lengths. It then compares every clock of `txd`, `txen`, `tx_done` and `src_rewind` against a timeline it builds from the requirements. A correct design must suppress `tx_done`, jam in the very next clock and resend the whole frame.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_DATA  = 3'd2,
    ST_JAM   = 3'd3,
    ST_BKOFF = 3'd4,
    ST_GAP   = 3'd5
  } sfd_state_e;

  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_START    = 4'hD;
  localparam logic [3:0] NIB_JAM      = 4'h5;
endpackage

// File: rtl/sfd_line_gate.sv
module sfd_line_gate #(
  parameter int NIB_W = 4
) (
  input  logic             loopback,
  input  logic             col_raw,
  input  logic             crs_raw,
  input  logic [NIB_W-1:0] txd_int,
  input  logic             txen_int,
  output logic             col_i,
  output logic             crs_i,
  output logic [NIB_W-1:0] txd,
  output logic             txen
);
  always_comb begin
    col_i = col_raw & ~loopback;
    crs_i = crs_raw & ~loopback;
    txd   = loopback ? '0 : txd_int;
    txen  = txen_int & ~loopback;
  end
endmodule

// File: rtl/sfd_nib_mux.sv
module sfd_nib_mux
  import sfd_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  sfd_state_e       state,
  input  logic             pre_last,
  input  logic [NIB_W-1:0] src_nib,
  output logic [NIB_W-1:0] txd_int,
  output logic             txen_int
);
  always_comb begin
    txd_int  = '0;
    txen_int = 1'b0;
    unique case (state)
      ST_PRE: begin
        txen_int = 1'b1;
        txd_int  = pre_last ? NIB_W'(NIB_START) : NIB_W'(NIB_PREAMBLE);
      end
      ST_DATA: begin
        txen_int = 1'b1;
        txd_int  = src_nib;
      end
      ST_JAM: begin
        txen_int = 1'b1;
        txd_int  = NIB_W'(NIB_JAM);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sfd_seq_fsm.sv
module sfd_seq_fsm
  import sfd_pkg::*;
#(
  parameter int PRE_NIBS = 15,
  parameter int GAP_NIBS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       col_i,
  input  logic       crs_i,
  input  logic       src_last,
  output sfd_state_e state,
  output logic       pre_last,
  output logic       src_rd,
  output logic       src_rewind,
  output logic       tx_done
);
  localparam int SPAN  = (PRE_NIBS + 1 > GAP_NIBS) ? PRE_NIBS + 1 : GAP_NIBS;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_NIBS);
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_NIBS - 1);

  sfd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             retry_q, retry_d;
  logic             gap_last;
  logic             cnt_en, pend_en, retry_en;

  assign state    = state_q;
  assign pre_last = (state_q == ST_PRE) && (cnt_q == PRE_END);
  assign gap_last = (state_q == ST_GAP) && (cnt_q == GAP_END);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    retry_d    = retry_q;
    src_rd     = 1'b0;
    src_rewind = 1'b0;
    tx_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (tx_req) state_d = ST_PRE;
      end
      ST_PRE: begin
        if (pre_last) begin
          cnt_d   = '0;
          pend_d  = 1'b0;
          state_d = (pend_q || col_i) ? ST_JAM : ST_DATA;
        end else begin
          cnt_d  = cnt_q + CNT_W'(1);
          pend_d = pend_q | col_i;
        end
      end
      ST_DATA: begin
        src_rd = 1'b1;
        if (col_i) begin
          state_d = ST_JAM;
        end else if (src_last) begin
          tx_done = 1'b1;
          retry_d = 1'b0;
          cnt_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_JAM: begin
        src_rewind = 1'b1;
        state_d    = ST_BKOFF;
      end
      ST_BKOFF: begin
        retry_d = 1'b1;
        cnt_d   = '0;
        state_d = ST_GAP;
      end
      ST_GAP: begin
        if (gap_last) begin
          cnt_d   = '0;
          state_d = retry_q ? ST_PRE : ST_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en   = (cnt_d != cnt_q);
  assign pend_en  = (state_q == ST_PRE);
  assign retry_en = (state_q == ST_BKOFF) || (state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (pend_en)  pend_q  <= pend_d;
      if (retry_en) retry_q <= retry_d;
    end
  end

  AST_START_IGNORES_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && tx_req && crs_i) |=> (state_q == ST_PRE)); // R4
  AST_DONE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (state_q == ST_DATA && src_rd)); // R3
  AST_JAM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_JAM) |=> (state_q == ST_BKOFF)); // R5
  AST_BKOFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BKOFF) |=> (state_q == ST_GAP && cnt_q == '0)); // R5
  AST_PRE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && !pre_last) |=> (state_q == ST_PRE)); // R6
  AST_RETRY_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_last && retry_q) |=> (state_q == ST_PRE && cnt_q == '0)); // R7
endmodule

// File: rtl/sfd_tx_seq.sv
module sfd_tx_seq
  import sfd_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int PRE_NIBS = 15,
  parameter int GAP_NIBS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loopback,
  input  logic             tx_req,
  output logic             tx_done,
  input  logic [NIB_W-1:0] src_nib,
  input  logic             src_last,
  output logic             src_rd,
  output logic             src_rewind,
  input  logic             crs,
  input  logic             col,
  output logic [NIB_W-1:0] txd,
  output logic             txen
);
  sfd_state_e       state;
  logic             pre_last;
  logic             col_i, crs_i;
  logic [NIB_W-1:0] txd_int;
  logic             txen_int;

  sfd_seq_fsm #(.PRE_NIBS(PRE_NIBS), .GAP_NIBS(GAP_NIBS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .col_i(col_i), .crs_i(crs_i),
    .src_last(src_last), .state(state), .pre_last(pre_last),
    .src_rd(src_rd), .src_rewind(src_rewind), .tx_done(tx_done)
  );

  sfd_nib_mux #(.NIB_W(NIB_W)) u_mux (
    .state(state), .pre_last(pre_last), .src_nib(src_nib),
    .txd_int(txd_int), .txen_int(txen_int)
  );

  sfd_line_gate #(.NIB_W(NIB_W)) u_gate (
    .loopback(loopback), .col_raw(col), .crs_raw(crs),
    .txd_int(txd_int), .txen_int(txen_int),
    .col_i(col_i), .crs_i(crs_i), .txd(txd), .txen(txen)
  );

  AST_LB_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && $past(loopback) && (state == ST_DATA)) |=> !src_rewind); // R8
endmodule

// File: tb/sfd_tx_seq_bench.sv
`timescale 1ns/1ps
module sfd_tx_seq_bench;
  localparam int MAXT = 320;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       loopback, tx_req, crs, col;
  logic       tx_done, src_rd, src_rewind, txen, src_last;
  logic [3:0] src_nib, txd;

  int n_vec = 0;
  int n_bad = 0;
  int cur_len = 1;
  int idx = 0;

  logic       e_en   [MAXT];
  logic [3:0] e_d    [MAXT];
  logic       e_done [MAXT];
  logic       e_rw   [MAXT];
  logic       c_at   [MAXT];
  int         n_cyc;

  always #2.5 clk = ~clk;

  sfd_tx_seq u_sfd_tx_seq (
    .clk(clk), .rst_n(rst_n), .loopback(loopback), .tx_req(tx_req),
    .tx_done(tx_done), .src_nib(src_nib), .src_last(src_last),
    .src_rd(src_rd), .src_rewind(src_rewind), .crs(crs), .col(col),
    .txd(txd), .txen(txen)
  );

  function automatic logic [3:0] dat(int i, int len);
    return 4'((i * 7 + 3 + len) & 15);
  endfunction

  assign src_nib  = dat(idx, cur_len);
  assign src_last = (idx == cur_len - 1);

  always @(posedge clk) begin
    if (src_rewind) idx <= 0;
    else if (src_rd) idx <= idx + 1;
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Clean attempt timeline relative to attempt start r
  task automatic put_clean(int t, int r, int len);
    if (r < 15)            begin e_en[t] = 1'b1; e_d[t] = 4'h5; end
    else if (r == 15)      begin e_en[t] = 1'b1; e_d[t] = 4'hD; end
    else if (r < 16 + len) begin e_en[t] = 1'b1; e_d[t] = dat(r - 16, len); end
    if (r == 15 + len) e_done[t] = 1'b1;
  endtask

  task automatic build(int len, int ca0, int ca1, int ca2, bit lb);
    int ca[4];
    int s;
    ca[0] = ca0; ca[1] = ca1; ca[2] = ca2; ca[3] = -1;
    for (int t = 0; t < MAXT; t++) begin
      e_en[t] = 1'b0; e_d[t] = 4'h0; e_done[t] = 1'b0; e_rw[t] = 1'b0; c_at[t] = 1'b0;
    end
    s = 0;
    for (int a = 0; a < 4; a++) begin
      int c;
      c = ca[a];
      if (c >= 0) c_at[s + c] = 1'b1;
      if (!lb && c >= 0 && c < 16 + len) begin
        int j;
        j = s + ((c < 16) ? 16 : c + 1);
        for (int t = s; t < j; t++) put_clean(t, t - s, len);
        e_done[s + 15 + len] = 1'b0;
        e_en[j] = 1'b1; e_d[j] = 4'h5; e_rw[j] = 1'b1;
        s = j + 26;
      end else begin
        for (int t = s; t < s + 16 + len; t++) put_clean(t, t - s, len);
        n_cyc = s + 16 + len + 24 + 2;
        break;
      end
    end
    if (lb) for (int t = 0; t < MAXT; t++) begin e_en[t] = 1'b0; e_d[t] = 4'h0; end
  endtask

  task automatic run(string tag, int len, int ca0, int ca1, int ca2, bit lb, bit crs_hi);
    build(len, ca0, ca1, ca2, lb);
    @(negedge clk);
    cur_len = len; idx = 0; loopback = lb; tx_req = 1'b1; col = 1'b0;
    crs = crs_hi;
    for (int t = 0; t < n_cyc; t++) begin
      @(negedge clk);
      tx_req = 1'b0;
      col = c_at[t];
      crs = crs_hi ? 1'b1 : 1'(((t * 5) + len) % 3 == 0);
      #1;
      chk(tag, "txen",       int'(txen),       int'(e_en[t]));
      chk(tag, "txd",        int'(txd),        int'(e_d[t]));
      chk(tag, "tx_done",    int'(tx_done),    int'(e_done[t]));
      chk(tag, "src_rewind", int'(src_rewind), int'(e_rw[t]));
    end
    col = 1'b0; loopback = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; loopback = 1'b0; tx_req = 1'b0; crs = 1'b0; col = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "txen",       int'(txen), 0);
    chk("R1", "txd",        int'(txd), 0);
    chk("R1", "tx_done",    int'(tx_done), 0);
    chk("R1", "src_rewind", int'(src_rewind), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      int len;
      len = (k == 4) ? 6 : k + 1;
      run("R2 R3", len, -1, -1, -1, 1'b0, 1'b0);
      run("R4",    len, -1, -1, -1, 1'b0, 1'b1);
      run("R6",    len, 0, -1, -1, 1'b0, 1'b0);
      run("R6",    len, 7, -1, -1, 1'b0, 1'b0);
      run("R6",    len, 15, -1, -1, 1'b0, 1'b0);
      run("R5",    len, 16, -1, -1, 1'b0, 1'b0);
      run("R5",    len, 15 + len, -1, -1, 1'b0, 1'b0);
      run("R9",    len, 16 + len + 2, -1, -1, 1'b0, 1'b0);
      run("R7",    len, 3, 15 + len, -1, 1'b0, 1'b0);
      run("R7",    len, 16, 0, 15 + len, 1'b0, 1'b0);
      run("R8",    len, 5, -1, -1, 1'b1, 1'b0);
      run("R8",    len, 15 + len, -1, -1, 1'b1, 1'b1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule